// File: doc/BRIEF.md
# Page-Triggered Sprite Copy DMA

This block copies one 256-byte page of CPU-visible memory into a 256-byte sprite attribute store. The CPU starts a copy by writing a page number to the trigger input. From the next cycle the engine holds the CPU in a stall through its halt output, because the CPU uses the shared bus on every clock and cannot run beside the copy. It then spends one idle cycle, followed by 256 pairs of cycles. In each pair it reads one byte through its bus master port and writes that byte into sprite memory. When the last byte is written it releases the CPU and gives a one-cycle completion pulse.

Bytes land in sprite memory at a destination pointer that the CPU can load beforehand. The pointer steps by one per written byte and wraps at 256, so a copy started at a nonzero pointer fills the store from that offset round to just below it. After a full copy the pointer is back at its starting value. Video and audio logic run on their own and keep going during the stall. The engine only drives the halt signal to the CPU.

Top module: `page_copy_dma`

## Requirements
- R1: In the cycle after a synchronous reset: halt=0, done=0, mem_rd=0, spr_we=0 and spr_addr=0.
- R2: A trigger write accepted while idle raises halt in the next cycle. That first halted cycle is a dummy cycle with mem_rd=0 and spr_we=0.
- R3: halt stays high for exactly 513 consecutive cycles per copy: 1 dummy cycle and 512 transfer cycles.
- R4: Byte k (k = 0..255, in ascending order) is read in a cycle with mem_rd=1 and mem_addr = {page, k}, where the page is in bits 15:8 and k in bits 7:0. The byte read in that cycle is what mem_rdata shows then. The very next cycle writes it with spr_we=1 and spr_wdata equal to that byte.
- R5: mem_rd and spr_we are never high in the same cycle, and neither is high while halt is low.
- R6: The write of byte k goes to spr_addr = (start + k) mod 256, where start is the pointer value when the copy was triggered. The pointer steps by one after each write and equals start again after the copy.
- R7: done is high for exactly one cycle: the first cycle with halt low after the 256th write.
- R8: A trigger write made while halt is high is ignored. The source page, the byte order and the 513-cycle length of the running copy are unchanged.
- R9: ptr_we while idle loads ptr_wdata into the pointer, and spr_addr shows it in the next cycle. ptr_we while halt is high is ignored.
- R10: A reset during a copy ends it at once. In the next cycle halt=0, done=0 and spr_addr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_we | input | 1 | CPU write strobe to the trigger register |
| trig_page | input | 8 | Source page number written with the trigger |
| ptr_we | input | 1 | CPU write strobe to the destination pointer |
| ptr_wdata | input | 8 | New destination pointer value |
| mem_addr | output | 16 | Bus master address: {page, byte index} |
| mem_rd | output | 1 | Bus master read strobe |
| mem_rdata | input | 8 | Read data returned in the same cycle |
| spr_addr | output | 8 | Sprite memory address (the current destination pointer) |
| spr_wdata | output | 8 | Sprite memory write data |
| spr_we | output | 1 | Sprite memory write strobe |
| halt | output | 1 | CPU stall request, high for the whole copy |
| done | output | 1 | One-cycle pulse when the CPU is released |

## Verification
The bench builds the block with its default parameters: an 8-bit page, a 256-byte page and one dummy cycle. With these values the exact 513-cycle stall and the full 8-bit pointer wrap can be observed at the ports. The stimulus table covers start pointers of 0x00, 0x01, 0x80, 0xFE and 0xFF and the extreme pages 0x00 and 0xFF. These values reach the wrap from the last sprite slot to slot 0 at different points in a copy. Directed cases add a trigger and a pointer load injected in the middle of a copy, and a reset during a copy.

// File: rtl/dma_pkg.sv
package dma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DUMMY = 2'd1,
      ST_RD    = 2'd2,
      ST_WR    = 2'd3
   } dma_state_t;
endpackage

// File: rtl/dma_seq.sv
module dma_seq
   import dma_pkg::*;
#(
   parameter int IDX_W        = 8,
   parameter int DUMMY_CYCLES = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             trig_we,
   output logic             start,
   output logic             busy,
   output logic             rd_phase,
   output logic             wr_phase,
   output logic [IDX_W-1:0] idx,
   output logic             done
);
   localparam int TOTAL_CYC = DUMMY_CYCLES + 2 * (2 ** IDX_W);
   localparam int CHK_W     = $clog2(TOTAL_CYC + 2);
   localparam int DCW       = (DUMMY_CYCLES > 1) ? $clog2(DUMMY_CYCLES) : 1;

   dma_state_t       state_q;
   dma_state_t       entry_st;
   logic [IDX_W-1:0] idx_q;
   logic             done_q;
   logic             dummy_last;

   generate
      if (DUMMY_CYCLES < 0) begin : g_bad_dummy
         $error("DUMMY_CYCLES must not be negative");
      end
      if (DUMMY_CYCLES == 0) begin : g_no_dummy
         assign entry_st   = ST_RD;
         assign dummy_last = 1'b1;
      end else begin : g_dummy
         logic [DCW-1:0] dcnt_q;
         always_ff @(posedge clk) begin
            if (rst || state_q != ST_DUMMY) dcnt_q <= '0;
            else                            dcnt_q <= dcnt_q + 1'b1;
         end
         assign entry_st   = ST_DUMMY;
         assign dummy_last = (dcnt_q == DCW'(DUMMY_CYCLES - 1));
      end
   endgenerate

   assign start = trig_we && (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               idx_q <= '0;
               if (trig_we) state_q <= entry_st;
            end
            ST_DUMMY: if (dummy_last) state_q <= ST_RD;
            ST_RD:    state_q <= ST_WR;
            ST_WR: begin
               if (idx_q == '1) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_RD;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign rd_phase = (state_q == ST_RD);
   assign wr_phase = (state_q == ST_WR);
   assign idx      = idx_q;
   assign done     = done_q;

   // Stall-length checker: busy cycles of one copy never exceed TOTAL_CYC
   logic [CHK_W-1:0] chk_cnt_q;
   always_ff @(posedge clk) begin
      if (rst || !busy) chk_cnt_q <= '0;
      else              chk_cnt_q <= chk_cnt_q + 1'b1;
   end

   a_r3_stall_bounded: assert property (@(posedge clk) disable iff (rst)
      busy |-> (chk_cnt_q < CHK_W'(TOTAL_CYC)));

   a_r3_done_at_full_length: assert property (@(posedge clk) disable iff (rst)
      (busy && chk_cnt_q == CHK_W'(TOTAL_CYC - 1)) |=> (!busy && done));
endmodule

// File: rtl/dma_src_addr.sv
module dma_src_addr #(
   parameter int PAGE_W = 8,
   parameter int IDX_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    start,
   input  logic                    busy,
   input  logic                    trig_we,
   input  logic [PAGE_W-1:0]       trig_page,
   input  logic [IDX_W-1:0]        idx,
   output logic [PAGE_W+IDX_W-1:0] mem_addr
);
   logic [PAGE_W-1:0] page_q;

   always_ff @(posedge clk) begin
      if (rst)        page_q <= '0;
      else if (start) page_q <= trig_page;
   end

   assign mem_addr = {page_q, idx};

   a_r8_page_held: assert property (@(posedge clk) disable iff (rst)
      (busy && trig_we) |=> $stable(page_q));
endmodule

// File: rtl/dma_dst_port.sv
module dma_dst_port #(
   parameter int IDX_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              busy,
   input  logic              rd_phase,
   input  logic              wr_phase,
   input  logic              ptr_we,
   input  logic [IDX_W-1:0]  ptr_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [IDX_W-1:0]  spr_addr,
   output logic [DATA_W-1:0] spr_wdata,
   output logic              spr_we
);
   logic [IDX_W-1:0]  ptr_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (rst)                   ptr_q <= '0;
      else if (wr_phase)         ptr_q <= ptr_q + 1'b1;
      else if (ptr_we && !busy)  ptr_q <= ptr_wdata;
   end

   always_ff @(posedge clk) begin
      if (rst)           data_q <= '0;
      else if (rd_phase) data_q <= mem_rdata;
   end

   assign spr_addr  = ptr_q;
   assign spr_wdata = data_q;
   assign spr_we    = wr_phase;

   a_r6_ptr_steps: assert property (@(posedge clk) disable iff (rst)
      spr_we |=> (spr_addr == $past(spr_addr) + 1'b1));

   a_r9_load_blocked: assert property (@(posedge clk) disable iff (rst)
      (busy && !spr_we) |=> $stable(spr_addr));
endmodule

// File: rtl/page_copy_dma.sv
module page_copy_dma #(
   parameter int PAGE_W       = 8,
   parameter int PAGE_BYTES   = 256,
   parameter int DATA_W       = 8,
   parameter int DUMMY_CYCLES = 1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      trig_we,
   input  logic [PAGE_W-1:0]         trig_page,
   input  logic                      ptr_we,
   input  logic [$clog2(PAGE_BYTES)-1:0] ptr_wdata,
   output logic [PAGE_W+$clog2(PAGE_BYTES)-1:0] mem_addr,
   output logic                      mem_rd,
   input  logic [DATA_W-1:0]         mem_rdata,
   output logic [$clog2(PAGE_BYTES)-1:0] spr_addr,
   output logic [DATA_W-1:0]         spr_wdata,
   output logic                      spr_we,
   output logic                      halt,
   output logic                      done
);
   localparam int IDX_W  = $clog2(PAGE_BYTES);

   generate
      if (PAGE_BYTES < 2 || PAGE_BYTES != (2 ** IDX_W)) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two of at least 2");
      end
      if (PAGE_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("PAGE_W and DATA_W must be at least 1");
      end
   endgenerate

   logic             start;
   logic             busy;
   logic             rd_phase;
   logic             wr_phase;
   logic [IDX_W-1:0] idx;

   dma_seq #(
      .IDX_W       (IDX_W),
      .DUMMY_CYCLES(DUMMY_CYCLES)
   ) u_seq (
      .clk     (clk),
      .rst     (rst),
      .trig_we (trig_we),
      .start   (start),
      .busy    (busy),
      .rd_phase(rd_phase),
      .wr_phase(wr_phase),
      .idx     (idx),
      .done    (done)
   );

   dma_src_addr #(
      .PAGE_W(PAGE_W),
      .IDX_W (IDX_W)
   ) u_src (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .busy     (busy),
      .trig_we  (trig_we),
      .trig_page(trig_page),
      .idx      (idx),
      .mem_addr (mem_addr)
   );

   dma_dst_port #(
      .IDX_W (IDX_W),
      .DATA_W(DATA_W)
   ) u_dst (
      .clk      (clk),
      .rst      (rst),
      .busy     (busy),
      .rd_phase (rd_phase),
      .wr_phase (wr_phase),
      .ptr_we   (ptr_we),
      .ptr_wdata(ptr_wdata),
      .mem_rdata(mem_rdata),
      .spr_addr (spr_addr),
      .spr_wdata(spr_wdata),
      .spr_we   (spr_we)
   );

   assign mem_rd = rd_phase;
   assign halt   = busy;

   a_r2_trigger_halts: assert property (@(posedge clk) disable iff (rst)
      (!halt && trig_we) |=> (halt && !mem_rd && !spr_we));

   a_r4_read_then_write: assert property (@(posedge clk) disable iff (rst)
      mem_rd |=> spr_we);

   a_r4_write_data: assert property (@(posedge clk) disable iff (rst)
      mem_rd |=> (spr_wdata == $past(mem_rdata)));

   a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && spr_we) && (halt || (!mem_rd && !spr_we)));

   a_r7_done_on_release: assert property (@(posedge clk) disable iff (rst)
      done |-> (!halt && $past(halt)));

   a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
endmodule

// File: tb/test_page_copy_dma.sv
module test_page_copy_dma;
   logic        clk = 1'b0;
   logic        rst;
   logic        trig_we;
   logic [7:0]  trig_page;
   logic        ptr_we;
   logic [7:0]  ptr_wdata;
   logic [15:0] mem_addr;
   logic        mem_rd;
   logic [7:0]  mem_rdata;
   logic [7:0]  spr_addr;
   logic [7:0]  spr_wdata;
   logic        spr_we;
   logic        halt;
   logic        done;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   function automatic logic [7:0] src_byte(input logic [15:0] a);
      logic [7:0] m;
      m = a[7:0] * 8'd7;
      return m ^ a[15:8] ^ 8'h31;
   endfunction

   assign mem_rdata = src_byte(mem_addr);

   page_copy_dma i_page_copy_dma (
      .clk      (clk),
      .rst      (rst),
      .trig_we  (trig_we),
      .trig_page(trig_page),
      .ptr_we   (ptr_we),
      .ptr_wdata(ptr_wdata),
      .mem_addr (mem_addr),
      .mem_rd   (mem_rd),
      .mem_rdata(mem_rdata),
      .spr_addr (spr_addr),
      .spr_wdata(spr_wdata),
      .spr_we   (spr_we),
      .halt     (halt),
      .done     (done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // {page, start pointer}
   localparam logic [15:0] VEC [6] = '{
      16'h0200, 16'h0701, 16'hFF80, 16'h00FF, 16'hA510, 16'h3CFE
   };

   // inject: 0 none, 1 trigger mid-copy (R8), 2 pointer load mid-copy (R9)
   task automatic do_copy(input logic [7:0] page, input logic [7:0] start, input int inject);
      int hcnt = 0, rcnt = 0, wcnt = 0, rerr = 0, werr = 0, oerr = 0;
      @(negedge clk);
      ptr_we = 1'b1; ptr_wdata = start;
      @(negedge clk);
      ptr_we = 1'b0;
      check(spr_addr == start, "R9", "pointer load while idle", spr_addr, start);
      trig_we = 1'b1; trig_page = page;
      @(negedge clk);
      trig_we = 1'b0;
      check(halt && !mem_rd && !spr_we, "R2", "dummy cycle after trigger",
            {halt, mem_rd, spr_we}, 3'b100);
      while (halt && hcnt < 2000) begin
         hcnt++;
         if (mem_rd) begin
            if (mem_addr != {page, 8'(rcnt)}) rerr++;
            rcnt++;
         end
         if (spr_we) begin
            if (spr_wdata != src_byte({page, 8'(wcnt)}) || spr_addr != 8'(start + 8'(wcnt))) werr++;
            wcnt++;
         end
         if (mem_rd && spr_we) oerr++;
         if (done) oerr++;
         if (inject == 1 && hcnt == 100) begin trig_we = 1'b1; trig_page = page ^ 8'h5A; end
         if (inject == 2 && hcnt == 200) begin ptr_we = 1'b1; ptr_wdata = start ^ 8'h33; end
         @(negedge clk);
         trig_we = 1'b0;
         ptr_we  = 1'b0;
      end
      check(hcnt == 513, "R3", "halt length", hcnt, 513);
      check(rcnt == 256 && rerr == 0, "R4", "read addresses", rerr, 0);
      check(wcnt == 256 && werr == 0, "R6", "write data and destination", werr, 0);
      check(oerr == 0, "R5", "read/write overlap or early done", oerr, 0);
      check(spr_addr == start, "R6", "pointer back at start", spr_addr, start);
      check(done && !mem_rd && !spr_we, "R7", "done on release", done, 1);
      @(negedge clk);
      check(!done && !halt, "R7", "done is one cycle", done, 0);
      if (inject == 1) check(hcnt == 513 && rerr == 0, "R8", "mid-copy trigger ignored", rerr, 0);
      if (inject == 2) check(werr == 0, "R9", "mid-copy pointer load ignored", werr, 0);
   endtask

   initial begin
      rst = 1'b1; trig_we = 1'b0; trig_page = '0; ptr_we = 1'b0; ptr_wdata = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check(!halt && !done && !mem_rd && !spr_we && spr_addr == 8'h00, "R1",
            "reset state", {halt, done, mem_rd, spr_we}, 0);
      check(spr_addr == 8'h00, "R1", "pointer reset", spr_addr, 0);

      for (int i = 0; i < 6; i++) begin
         do_copy(VEC[i][15:8], VEC[i][7:0], 0);
      end

      do_copy(8'h12, 8'h40, 1);
      do_copy(8'h34, 8'hC0, 2);

      // R10: reset mid-copy
      @(negedge clk);
      ptr_we = 1'b1; ptr_wdata = 8'h77;
      @(negedge clk);
      ptr_we = 1'b0; trig_we = 1'b1; trig_page = 8'h55;
      @(negedge clk);
      trig_we = 1'b0;
      repeat (50) @(negedge clk);
      check(halt, "R10", "copy running before reset", halt, 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(!halt && !done && spr_addr == 8'h00, "R10", "reset ends copy",
            {halt, done, spr_addr}, 0);
      @(negedge clk);
      check(!halt && !mem_rd && !spr_we, "R10", "stays idle after reset", halt, 0);

      // R3: a fresh copy works after the aborted one
      do_copy(8'h01, 8'h00, 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule